// File: doc/BRIEF.md
# Key-Locked Byte Storage Controller

This block sits on a simple processor register bus and fronts a small byte-wide nonvolatile data store. It offers four byte registers chosen by a two-bit select: a data register, an address register, a control/status register and a write-only key register. A read copies the addressed byte into the data register and is visible one cycle later. A write moves the data register into the addressed byte. It runs only after an exact two-byte key has been written and a separately held write-enable bit is already set.

A write is self-timed. A busy bit stays up for a parameterised number of cycles and drops by itself. At the end a sticky completion flag rises and drives a level interrupt request. Software clears that flag by writing 0 to it. The storage is modelled as a register file with no reset.

There are two synchronous active-high resets. The power-on reset clears every register. The warm reset aborts a write in progress, records that abort in an error bit and keeps the address and data registers.

Top module: `nvm_byte_ctrl`

## Requirements
- R1: After power-on reset the data, address and control registers read 00h and `irq` is 0.
- R2: A bus write to the control register with bit 0 set, while not busy, loads the data register from the array byte at the current address; the value reads back on the next cycle and holds until another read or a bus write to the data register. Bit 0 always reads 0.
- R3: A write starts only when the key register receives 55h, then AAh, then the next bus write goes to the control register with bit 1 set. Any other byte, any write to another register, or a bus read of the key register between these steps returns the key logic to its start, and the unlocked state is consumed by the next bus write of any kind.
- R4: Write-enable (control bit 2) must already be 1 before the control write that sets bit 1; setting both in the same write starts nothing.
- R5: Write-enable changes only through bus writes, and clearing it while a write is busy does not cancel or alter that write.
- R6: Control bit 1 reads 1 for exactly WR_CYCLES cycles after the starting write. The target byte and its value are captured at the start and stored at the end. Read requests and start attempts made while busy are ignored.
- R7: At the end of a write, bit 1 clears and the done flag (bit 4) sets. Done and the error flag (bit 3) are each cleared only by a control write with that bit 0; writing 1 leaves them unchanged.
- R8: Register select codes are 0 data, 1 address, 2 control, 3 key. Control bits 7..5 read 0, the key register reads 00h, and the address reads zero-extended.
- R9: Warm reset aborts a busy write without changing the array, sets the error flag to 1 if a write was busy and to 0 otherwise, clears write-enable, busy, done and the key logic, and keeps the address and data registers.
- R10: `irq` equals the done flag at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Synchronous power-on reset, active high |
| rst | input | 1 | Synchronous warm reset, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_sel | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| irq | output | 1 | Level interrupt request, mirrors done flag |

## Verification
The hardest cases to reach are the ones that fall inside the busy window. These are a warm reset mid-write, a full key sequence with a start attempt while busy, and moving the address or clearing write-enable during a write. The bench overrides the write time to ten cycles so that a whole key sequence and start attempt fit inside one busy period, then issues each disturbance at a known offset from the starting edge. A behavioural model tracks every register and the array, and each cycle's read-back is compared against it.

// File: rtl/nvm_byte_pkg.sv
package nvm_byte_pkg;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_ADDR = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_KEY  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        KEY_IDLE = 2'd0,
        KEY_HALF = 2'd1,
        KEY_OPEN = 2'd2
    } key_state_e;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    localparam int CTL_RD   = 0;
    localparam int CTL_WR   = 1;
    localparam int CTL_WREN = 2;
    localparam int CTL_ERR  = 3;
    localparam int CTL_DONE = 4;

    typedef struct packed {
        logic     wr;
        logic     rd;
        reg_sel_e sel;
        logic [7:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic done;
        logic err;
        logic wren;
        logic busy;
    } ctl_state_t;

    function automatic logic [7:0] pack_ctl(ctl_state_t s);
        logic [7:0] v;
        v = 8'h00;
        v[CTL_DONE] = s.done;
        v[CTL_ERR]  = s.err;
        v[CTL_WREN] = s.wren;
        v[CTL_WR]   = s.busy;
        return v;
    endfunction

    function automatic logic hits(bus_req_t r, reg_sel_e s);
        return r.wr && (r.sel == s);
    endfunction

endpackage

// File: rtl/nvm_key_fsm.sv
module nvm_key_fsm
    import nvm_byte_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req,
    output logic     unlocked
);
    key_state_e st, nxt;

    always_comb begin
        nxt = st;
        if (req.wr) begin
            if (req.sel == SEL_KEY) begin
                case (st)
                    KEY_IDLE: nxt = (req.wdata == KEY_FIRST)  ? KEY_HALF : KEY_IDLE;
                    KEY_HALF: nxt = (req.wdata == KEY_SECOND) ? KEY_OPEN : KEY_IDLE;
                    default:  nxt = KEY_IDLE;
                endcase
            end else begin
                nxt = KEY_IDLE;
            end
        end else if (req.rd && req.sel == SEL_KEY) begin
            nxt = KEY_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= KEY_IDLE;
        else     st <= nxt;
    end

    assign unlocked = (st == KEY_OPEN);

    // R3
    key_order_chk: assert property (@(posedge clk) disable iff (rst)
        (st == KEY_OPEN && $past(st) != KEY_OPEN) |->
            ($past(st) == KEY_HALF && $past(req.wr && req.sel == SEL_KEY && req.wdata == KEY_SECOND)));
endmodule

// File: rtl/nvm_wr_timer.sv
module nvm_wr_timer #(
    parameter int unsigned CYCLES = 200
) (
    input  logic clk,
    input  logic abort,
    input  logic start,
    output logic busy,
    output logic fin
);
    localparam int unsigned CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] cnt;
    logic             busy_q;

    always_ff @(posedge clk) begin
        if (abort) begin
            busy_q <= 1'b0;
            cnt    <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt    <= LAST;
        end else if (busy_q) begin
            if (cnt == '0) busy_q <= 1'b0;
            else           cnt    <= cnt - 1'b1;
        end
    end

    assign busy = busy_q;
    assign fin  = busy_q && (cnt == '0);

    // R6
    busy_hold_chk: assert property (@(posedge clk) disable iff (abort)
        (busy_q && !fin) |=> busy_q);

    // R6
    busy_end_chk: assert property (@(posedge clk) disable iff (abort)
        $fell(busy_q) |-> $past(fin || abort));
endmodule

// File: rtl/nvm_cell_array.sv
module nvm_cell_array #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/nvm_byte_ctrl.sv
module nvm_byte_ctrl
    import nvm_byte_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int WR_CYCLES = 200
) (
    input  logic       clk,
    input  logic       por,
    input  logic       rst,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [1:0] bus_sel,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq
);
    localparam int PAD_W = 8 - ADDR_W;

    bus_req_t req;
    logic     any_rst;
    logic     unlocked, busy, fin;
    logic     wr_ctl, rd_go, start;
    logic [ADDR_W-1:0] addr_q, lat_addr;
    logic [7:0]        data_q, lat_data, arr_rdata;
    logic              wren_q, done_q, err_q;
    ctl_state_t        ctl;

    assign req.wr    = bus_wr;
    assign req.rd    = bus_rd;
    assign req.sel   = reg_sel_e'(bus_sel);
    assign req.wdata = bus_wdata;
    assign any_rst   = por | rst;

    assign wr_ctl = hits(req, SEL_CTRL);
    assign rd_go  = wr_ctl && bus_wdata[CTL_RD] && !busy;
    assign start  = wr_ctl && bus_wdata[CTL_WR] && unlocked && wren_q && !busy;

    nvm_key_fsm u_key (
        .clk      (clk),
        .rst      (any_rst),
        .req      (req),
        .unlocked (unlocked)
    );

    nvm_wr_timer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk   (clk),
        .abort (any_rst),
        .start (start),
        .busy  (busy),
        .fin   (fin)
    );

    nvm_cell_array #(.ADDR_W(ADDR_W)) u_array (
        .clk   (clk),
        .we    (fin && !any_rst),
        .waddr (lat_addr),
        .wdata (lat_data),
        .raddr (addr_q),
        .rdata (arr_rdata)
    );

    always_ff @(posedge clk) begin
        if (start) begin
            lat_addr <= addr_q;
            lat_data <= data_q;
        end
    end

    always_ff @(posedge clk) begin
        if (por) begin
            addr_q <= '0;
            data_q <= '0;
        end else begin
            if (hits(req, SEL_ADDR)) addr_q <= bus_wdata[ADDR_W-1:0];
            if (hits(req, SEL_DATA)) data_q <= bus_wdata;
            else if (rd_go)          data_q <= arr_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (por) begin
            wren_q <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else if (rst) begin
            wren_q <= 1'b0;
            done_q <= 1'b0;
            err_q  <= busy;
        end else begin
            if (wr_ctl) begin
                wren_q <= bus_wdata[CTL_WREN];
                if (!bus_wdata[CTL_DONE]) done_q <= 1'b0;
                if (!bus_wdata[CTL_ERR])  err_q  <= 1'b0;
            end
            if (fin) done_q <= 1'b1;
        end
    end

    assign ctl.done = done_q;
    assign ctl.err  = err_q;
    assign ctl.wren = wren_q;
    assign ctl.busy = busy;

    always_comb begin
        case (req.sel)
            SEL_DATA: bus_rdata = data_q;
            SEL_ADDR: bus_rdata = {{PAD_W{1'b0}}, addr_q};
            SEL_CTRL: bus_rdata = pack_ctl(ctl);
            default:  bus_rdata = 8'h00;
        endcase
    end

    assign irq = done_q;

    // R4
    wren_gate_chk: assert property (@(posedge clk) disable iff (any_rst)
        $rose(busy) |-> $past(wren_q && unlocked));

    // R7
    done_sticky_chk: assert property (@(posedge clk) disable iff (any_rst)
        $fell(done_q) |-> $past((wr_ctl && !bus_wdata[CTL_DONE]) || any_rst));

    // R6
    busy_data_chk: assert property (@(posedge clk) disable iff (any_rst)
        (busy && !hits(req, SEL_DATA)) |=> $stable(data_q));

    // R9
    abort_err_chk: assert property (@(posedge clk) disable iff (por)
        ($past(rst) && !$past(por) && $past(busy)) |-> (err_q && !busy));
endmodule

// File: tb/test_nvm_byte_ctrl.sv
module test_nvm_byte_ctrl;
    localparam int AW = 6;
    localparam int WC = 10;

    logic       clk = 1'b0;
    logic       por, rst, bus_wr, bus_rd;
    logic [1:0] bus_sel;
    logic [7:0] bus_wdata;
    wire  [7:0] bus_rdata;
    wire        irq;

    always #4 clk = ~clk;

    nvm_byte_ctrl #(.ADDR_W(AW), .WR_CYCLES(WC)) i_nvm_byte_ctrl (
        .clk(clk), .por(por), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [7:0]    m_mem [64];
    logic [7:0]    m_data, m_ld;
    logic [AW-1:0] m_addr, m_la;
    bit            m_wren, m_done, m_err, m_busy;
    int            m_cnt, m_key;

    function automatic logic [7:0] m_read(int sel);
        case (sel)
            0: return m_data;
            1: return {2'b00, m_addr};
            2: return {3'b000, m_done, m_err, m_wren, m_busy, 1'b0};
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_edge(bit p, bit r, bit w, bit rd, int sel, logic [7:0] d);
        bit ob, ow; int ok; bit fin_now;
        ob = m_busy; ow = m_wren; ok = m_key; fin_now = 0;
        if (p) begin
            m_data = 0; m_addr = 0; m_wren = 0; m_done = 0; m_err = 0;
            m_busy = 0; m_cnt = 0; m_key = 0;
        end else if (r) begin
            m_err = ob; m_busy = 0; m_wren = 0; m_done = 0; m_key = 0;
        end else begin
            if (ob) begin
                if (m_cnt == 0) begin m_mem[m_la] = m_ld; m_busy = 0; fin_now = 1; end
                else m_cnt--;
            end
            if (w) begin
                if (sel == 3) begin
                    if (ok == 0 && d == 8'h55) m_key = 1;
                    else if (ok == 1 && d == 8'hAA) m_key = 2;
                    else m_key = 0;
                end else m_key = 0;
            end else if (rd && sel == 3) m_key = 0;
            if (w) begin
                case (sel)
                    0: m_data = d;
                    1: m_addr = d[AW-1:0];
                    2: begin
                        if (d[1] && ok == 2 && ow && !ob) begin
                            m_busy = 1; m_cnt = WC - 1; m_la = m_addr; m_ld = m_data;
                        end
                        if (d[0] && !ob) m_data = m_mem[m_addr];
                        m_wren = d[2];
                        if (!d[4]) m_done = 0;
                        if (!d[3]) m_err = 0;
                    end
                    default: ;
                endcase
            end
            if (fin_now) m_done = 1;
        end
    endtask

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
        end
    endtask

    task automatic step(string tag, bit w, bit rd, int sel, logic [7:0] d, bit p = 0, bit r = 0);
        por = p; rst = r; bus_wr = w; bus_rd = rd; bus_sel = 2'(sel); bus_wdata = d;
        #1;
        if (!p) begin
            check(tag, bus_rdata, m_read(sel), "rdata vs model");
            check(tag, {7'b0, irq}, {7'b0, m_done}, "irq vs model");
        end
        @(posedge clk);
        model_edge(p, r, w, rd, sel, d);
        @(negedge clk);
    endtask

    task automatic wr(string tag, int sel, logic [7:0] d);
        step(tag, 1, 0, sel, d);
    endtask

    task automatic peek(string tag, int sel);
        step(tag, 0, 1, sel, 8'h00);
    endtask

    task automatic expect_reg(string tag, int sel, logic [7:0] exp);
        por = 0; rst = 0; bus_wr = 0; bus_rd = 0; bus_sel = 2'(sel); bus_wdata = 0;
        #1;
        check(tag, bus_rdata, exp, "fixed value");
        @(posedge clk);
        model_edge(0, 0, 0, 0, sel, 8'h00);
        @(negedge clk);
    endtask

    task automatic unlock_start(string tag);
        wr(tag, 3, 8'h55);
        wr(tag, 3, 8'hAA);
        wr(tag, 2, 8'h06);
    endtask

    task automatic wait_ctl(string tag, int n);
        for (int i = 0; i < n; i++) peek(tag, 2);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL R6 watchdog: actual %0d cycles expected under 20000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        por = 1; rst = 0; bus_wr = 0; bus_rd = 0; bus_sel = 0; bus_wdata = 0;
        @(negedge clk);
        step("R1", 0, 0, 2, 8'h00, 1);
        step("R1", 0, 0, 2, 8'h00, 1);
        expect_reg("R1", 0, 8'h00);
        expect_reg("R1", 1, 8'h00);
        expect_reg("R1", 2, 8'h00);
        check("R10", {7'b0, irq}, 8'h00, "irq after reset");
        expect_reg("R8", 3, 8'h00);

        // First write: A5 to byte 5
        wr("R3", 1, 8'h05);
        wr("R3", 0, 8'hA5);
        wr("R3", 2, 8'h04);
        unlock_start("R3");
        wait_ctl("R6", WC + 2);
        check("R10", {7'b0, irq}, 8'h01, "irq after write end");
        expect_reg("R7", 2, 8'h14);
        wr("R7", 2, 8'h14);
        expect_reg("R7", 2, 8'h14);
        wr("R7", 2, 8'h04);
        expect_reg("R7", 2, 8'h04);
        check("R10", {7'b0, irq}, 8'h00, "irq after clear");

        // Read back
        wr("R2", 0, 8'h00);
        wr("R2", 2, 8'h05);
        expect_reg("R2", 0, 8'hA5);
        expect_reg("R2", 2, 8'h04);
        wait_ctl("R2", 3);
        expect_reg("R2", 0, 8'hA5);

        // Second write: 3C to byte 6, disturbed while busy
        wr("R6", 1, 8'h06);
        wr("R6", 0, 8'h3C);
        unlock_start("R6");
        wr("R6", 1, 8'h05);
        wr("R5", 2, 8'h01);
        expect_reg("R5", 2, 8'h02);
        wr("R6", 2, 8'h04);
        unlock_start("R6");
        peek("R6", 0);
        wait_ctl("R6", WC);
        expect_reg("R6", 2, 8'h14);
        wr("R7", 2, 8'h04);
        wr("R6", 1, 8'h06);
        wr("R6", 2, 8'h05);
        expect_reg("R6", 0, 8'h3C);
        wr("R6", 1, 8'h05);
        wr("R6", 2, 8'h05);
        expect_reg("R6", 0, 8'hA5);

        // Broken key sequences: nothing may start
        wr("R3", 1, 8'h06);
        wr("R3", 0, 8'h77);
        wr("R3", 3, 8'hAA); wr("R3", 3, 8'h55); wr("R3", 2, 8'h06); peek("R3", 2);
        wr("R3", 3, 8'h55); wr("R3", 0, 8'h77); wr("R3", 3, 8'hAA); wr("R3", 2, 8'h06); peek("R3", 2);
        wr("R3", 3, 8'h55); peek("R3", 3); wr("R3", 3, 8'hAA); wr("R3", 2, 8'h06); peek("R3", 2);
        wr("R3", 3, 8'h55); wr("R3", 3, 8'h55); wr("R3", 3, 8'hAA); wr("R3", 2, 8'h06); peek("R3", 2);
        wr("R3", 3, 8'h55); wr("R3", 3, 8'hAA); wr("R3", 1, 8'h06); wr("R3", 2, 8'h06);
        expect_reg("R3", 2, 8'h04);
        wr("R3", 2, 8'h05);
        expect_reg("R3", 0, 8'h3C);

        // Write-enable set in the same write as the start bit
        wr("R4", 0, 8'h77);
        wr("R4", 2, 8'h00);
        unlock_start("R4");
        expect_reg("R4", 2, 8'h04);
        unlock_start("R4");
        expect_reg("R4", 2, 8'h06);
        wait_ctl("R4", WC);
        wr("R4", 2, 8'h05);
        expect_reg("R4", 0, 8'h77);

        // Warm reset during a write
        wr("R9", 0, 8'h11);
        unlock_start("R9");
        wait_ctl("R9", 3);
        step("R9", 0, 0, 2, 8'h00, 0, 1);
        expect_reg("R9", 2, 8'h08);
        expect_reg("R9", 1, 8'h06);
        expect_reg("R9", 0, 8'h11);
        wait_ctl("R9", WC + 1);
        check("R10", {7'b0, irq}, 8'h00, "irq after abort");
        wr("R9", 2, 8'h09);
        expect_reg("R9", 0, 8'h77);
        wr("R7", 2, 8'h08);
        expect_reg("R7", 2, 8'h08);
        step("R9", 0, 0, 2, 8'h00, 0, 1);
        expect_reg("R9", 2, 8'h00);

        // Power-on reset again
        step("R1", 0, 0, 2, 8'h00, 1);
        expect_reg("R1", 0, 8'h00);
        expect_reg("R1", 1, 8'h00);
        expect_reg("R1", 2, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule